// File: doc/BRIEF.md
# Logarithmic 8-bit Integer Codec

This block squeezes a 20-bit unsigned integer into a one-byte logarithmic symbol and expands a symbol back into an approximate 20-bit integer. A symbol holds a 4-bit band number (the exponent) and a 4-bit step within that band (the mantissa). Band e begins at the value (2^e − 1)·16, and inside it each step is 2^e wide. Small values up to 15 are therefore exact. Larger values lose precision in proportion to their size, so the relative error stays at or below one sixteenth.

The compress path and the expand path are independent. Each path has its own valid strobe and may be used in the same cycle as the other. Neither path uses a multiplier or a divider. Compression is a priority search over the 16 band start values, followed by a subtract and a right shift. Expansion is a left shift of the mantissa with a hidden leading one, followed by a subtract.

With the default output stage, each path returns its result one cycle after its strobe. The paths have no ready signal and accept a new input every cycle, so there is no back-pressure. A result is held until the next strobe on that path.

Top module: `log8_codec`

## Requirements
- R1: A code byte carries the exponent e in bits 7:4 and the mantissa m in bits 3:0.
- R2: The expand path returns (m+16)·2^e − 16 for every code. Examples: 0x00→0, 0x0F→15, 0x1F→46, 0xF0→524272, 0xFF→1015792.
- R3: The compress path returns the input value itself as the code for every input below 16.
- R4: For inputs from 16 to 1015792, the compress path selects e as the largest band whose start (2^e−1)·16 is not above the input, and sets m to (input − start) >> e.
- R5: Inputs above 1015792 compress to code 0xFF with enc_out_sat at 1. Every input up to 1015792 gives enc_out_sat at 0.
- R6: Each output valid rises exactly one cycle after its input valid, and that valid is low in any cycle not preceded by an input valid. A result holds its value while no new strobe arrives on its path.
- R7: While reset is asserted and just after it, both output valids are 0, enc_out_code, enc_out_sat and dec_out_value are 0.
- R8: For all 256 codes, compressing the expanded value returns the original code.
- R9: For every input from 16 to 1015792, the expanded result of the compressed code is not above the input, and the shortfall times 16 is not above the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_in_valid | input | 1 | Compress input strobe |
| enc_in_value | input | 20 | Unsigned value to compress |
| enc_out_valid | output | 1 | Compress result valid |
| enc_out_code | output | 8 | Compressed code: exponent in bits 7:4, mantissa in bits 3:0 |
| enc_out_sat | output | 1 | Input was above the largest representable value |
| dec_in_valid | input | 1 | Expand input strobe |
| dec_in_code | input | 8 | Code to expand |
| dec_out_valid | output | 1 | Expand result valid |
| dec_out_value | output | 20 | Expanded value |

## Verification
The assertions check the following properties on every cycle:
- the one-cycle valid latency on both paths, and that results hold while no strobe arrives;
- the saturate flag against the registered input, and the forced 0xFF code whenever it is raised;
- pass-through of small inputs;
- expansion of code zero.

Some properties cover whole value sets at once, and only the bench's sweeps can show them:
- the exact band choice and mantissa over many inputs;
- the closed-form expansion of all 256 codes;
- the code-to-value-to-code round trip;
- the 6.25% error bound.

// File: rtl/log8_pkg.sv
package log8_pkg;
  // Lowest value held by exponent band e: (2^e - 1) * 2^man_w.
  function automatic int unsigned band_base(input int unsigned e, input int unsigned man_w);
    return ((32'd1 << e) - 32'd1) << man_w;
  endfunction

  // Largest value the code can express: all-ones mantissa in the top band.
  function automatic int unsigned top_value(input int unsigned exp_w, input int unsigned man_w);
    return (((32'd1 << (man_w + 1)) - 32'd1) << ((32'd1 << exp_w) - 1)) - (32'd1 << man_w);
  endfunction
endpackage

// File: rtl/log8_encoder.sv
module log8_encoder #(
  parameter int EXP_W = 4,
  parameter int MAN_W = 4,
  parameter int VAL_W = 20
) (
  input  logic [VAL_W-1:0]       value,
  output logic [EXP_W+MAN_W-1:0] code,
  output logic                   sat
);
  localparam int NBANDS = 2 ** EXP_W;
  localparam logic [VAL_W-1:0] MAXV = VAL_W'(log8_pkg::top_value(EXP_W, MAN_W));

  logic [VAL_W-1:0] band_lo [NBANDS];
  logic [EXP_W-1:0] e_sel;
  logic [VAL_W-1:0] excess;
  logic [MAN_W-1:0] man;

  for (genvar g = 0; g < NBANDS; g++) begin : g_band
    assign band_lo[g] = VAL_W'(log8_pkg::band_base(g, MAN_W));
  end

  // Priority search: highest band whose start does not exceed the value.
  always_comb begin
    e_sel = '0;
    for (int i = 1; i < NBANDS; i++) begin
      if (value >= band_lo[i]) e_sel = EXP_W'(i);
    end
  end

  assign excess = value - band_lo[e_sel];
  assign man    = MAN_W'(excess >> e_sel);
  assign sat    = (value > MAXV);
  assign code   = sat ? '1 : {e_sel, man};
endmodule

// File: rtl/log8_decoder.sv
module log8_decoder #(
  parameter int EXP_W = 4,
  parameter int MAN_W = 4,
  parameter int VAL_W = 20
) (
  input  logic [EXP_W+MAN_W-1:0] code,
  output logic [VAL_W-1:0]       value
);
  localparam logic [VAL_W-1:0] BIAS = VAL_W'(2 ** MAN_W);

  logic [VAL_W-1:0] lead;

  // Mantissa with hidden leading one, shifted by the exponent, minus the bias.
  assign lead  = VAL_W'({1'b1, code[MAN_W-1:0]});
  assign value = (lead << code[EXP_W+MAN_W-1:MAN_W]) - BIAS;
endmodule

// File: rtl/log8_stage.sv
module log8_stage #(
  parameter int W          = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        out_data  <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) out_data <= in_data;
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end
endmodule

// File: rtl/log8_codec.sv
module log8_codec #(
  parameter int EXP_W      = 4,
  parameter int MAN_W      = 4,
  parameter bit REGISTERED = 1'b1,
  localparam int CODE_W    = EXP_W + MAN_W,
  localparam int VAL_W     = MAN_W + 1 + (2 ** EXP_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_in_valid,
  input  logic [VAL_W-1:0]  enc_in_value,
  output logic              enc_out_valid,
  output logic [CODE_W-1:0] enc_out_code,
  output logic              enc_out_sat,
  input  logic              dec_in_valid,
  input  logic [CODE_W-1:0] dec_in_code,
  output logic              dec_out_valid,
  output logic [VAL_W-1:0]  dec_out_value
);
  logic [CODE_W-1:0] enc_code;
  logic              enc_sat;
  logic [VAL_W-1:0]  dec_value;

  log8_encoder #(.EXP_W(EXP_W), .MAN_W(MAN_W), .VAL_W(VAL_W)) u_enc (
    .value (enc_in_value),
    .code  (enc_code),
    .sat   (enc_sat)
  );

  log8_decoder #(.EXP_W(EXP_W), .MAN_W(MAN_W), .VAL_W(VAL_W)) u_dec (
    .code  (dec_in_code),
    .value (dec_value)
  );

  log8_stage #(.W(CODE_W + 1), .REGISTERED(REGISTERED)) u_enc_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (enc_in_valid),
    .in_data   ({enc_sat, enc_code}),
    .out_valid (enc_out_valid),
    .out_data  ({enc_out_sat, enc_out_code})
  );

  log8_stage #(.W(VAL_W), .REGISTERED(REGISTERED)) u_dec_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (dec_in_valid),
    .in_data   (dec_value),
    .out_valid (dec_out_valid),
    .out_data  (dec_out_value)
  );
endmodule

// File: rtl/log8_codec_checks.sv
module log8_codec_checks #(
  parameter int EXP_W      = 4,
  parameter int MAN_W      = 4,
  parameter bit REGISTERED = 1'b1,
  localparam int CODE_W    = EXP_W + MAN_W,
  localparam int VAL_W     = MAN_W + 1 + (2 ** EXP_W) - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enc_in_valid,
  input logic [VAL_W-1:0]  enc_in_value,
  input logic              enc_out_valid,
  input logic [CODE_W-1:0] enc_out_code,
  input logic              enc_out_sat,
  input logic              dec_in_valid,
  input logic [CODE_W-1:0] dec_in_code,
  input logic              dec_out_valid,
  input logic [VAL_W-1:0]  dec_out_value
);
  localparam logic [VAL_W-1:0] MAXV  = VAL_W'(log8_pkg::top_value(EXP_W, MAN_W));
  localparam logic [VAL_W-1:0] SMALL = VAL_W'(2 ** MAN_W);

  // R5: a raised saturate flag always comes with the all-ones code
  p_sat_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_out_valid && enc_out_sat) |-> (enc_out_code == '1));

  if (REGISTERED) begin : g_seq
    p_enc_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      enc_in_valid |=> enc_out_valid);
    p_enc_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !enc_in_valid |=> !enc_out_valid);
    p_dec_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dec_in_valid |=> dec_out_valid);
    p_dec_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_in_valid |=> !dec_out_valid);
    p_enc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !enc_in_valid |=> ($stable(enc_out_code) && $stable(enc_out_sat)));
    p_dec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_in_valid |=> $stable(dec_out_value));
    // R5: flag follows the input range one cycle later
    p_sat_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      enc_in_valid |=> (enc_out_sat == ($past(enc_in_value) > MAXV)));
    // R3: small values pass through unchanged
    p_small_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_in_valid && (enc_in_value < SMALL)) |=>
        (VAL_W'(enc_out_code) == $past(enc_in_value)));
    // R2: code zero expands to zero
    p_zero_expand_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_in_valid && (dec_in_code == '0)) |=> (dec_out_value == '0));
  end
endmodule

bind log8_codec log8_codec_checks #(
  .EXP_W(EXP_W), .MAN_W(MAN_W), .REGISTERED(REGISTERED)
) u_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .enc_in_valid  (enc_in_valid),
  .enc_in_value  (enc_in_value),
  .enc_out_valid (enc_out_valid),
  .enc_out_code  (enc_out_code),
  .enc_out_sat   (enc_out_sat),
  .dec_in_valid  (dec_in_valid),
  .dec_in_code   (dec_in_code),
  .dec_out_valid (dec_out_valid),
  .dec_out_value (dec_out_value)
);

// File: tb/log8_codec_test.sv
module log8_codec_test;
  localparam int unsigned MAXV = 1015792;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_in_valid = 1'b0;
  logic [19:0] enc_in_value = '0;
  logic        enc_out_valid;
  logic [7:0]  enc_out_code;
  logic        enc_out_sat;
  logic        dec_in_valid = 1'b0;
  logic [7:0]  dec_in_code = '0;
  logic        dec_out_valid;
  logic [19:0] dec_out_value;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  log8_codec uut (
    .clk(clk), .rst_n(rst_n),
    .enc_in_valid(enc_in_valid), .enc_in_value(enc_in_value),
    .enc_out_valid(enc_out_valid), .enc_out_code(enc_out_code), .enc_out_sat(enc_out_sat),
    .dec_in_valid(dec_in_valid), .dec_in_code(dec_in_code),
    .dec_out_valid(dec_out_valid), .dec_out_value(dec_out_value)
  );

  function automatic int unsigned ref_dec(input int unsigned c);
    int unsigned e = c / 16;
    int unsigned m = c % 16;
    return (m + 16) * (2 ** e) - 16;
  endfunction

  // Largest code whose expansion does not exceed v (expansion is increasing).
  function automatic int unsigned ref_enc(input int unsigned v);
    if (v > MAXV) return 255;
    for (int c = 255; c >= 0; c--) begin
      if (ref_dec(c) <= v) return c;
    end
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_enc(input int unsigned v, output int unsigned code, output bit sat);
    @(negedge clk);
    enc_in_valid = 1'b1;
    enc_in_value = 20'(v);
    @(negedge clk);
    code = enc_out_code;
    sat  = enc_out_sat;
    enc_in_valid = 1'b0;
  endtask

  task automatic run_dec(input int unsigned c, output int unsigned val);
    @(negedge clk);
    dec_in_valid = 1'b1;
    dec_in_code  = 8'(c);
    @(negedge clk);
    val = dec_out_value;
    dec_in_valid = 1'b0;
  endtask

  task automatic enc_check(input int unsigned v);
    int unsigned code;
    bit sat;
    int unsigned exp_code = ref_enc(v);
    run_enc(v, code, sat);
    if (v < 16) check(code == v, "R3 small pass", code, v);
    else if (v <= MAXV) check(code == exp_code, "R4 band code", code, exp_code);
    else check(code == 255, "R5 saturated code", code, 255);
    check(sat == (v > MAXV), "R5 sat flag", sat, (v > MAXV));
    if (v >= 16 && v <= MAXV) begin
      int unsigned d = ref_dec(code);
      check((d <= v) && ((v - d) * 16 <= v), "R9 error bound", d, v);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    int unsigned code, val;
    bit sat;

    repeat (3) @(negedge clk);
    // R7: reset state
    check(!enc_out_valid && !dec_out_valid, "R7 valids in reset", {enc_out_valid, dec_out_valid}, 0);
    check(enc_out_code == 0 && !enc_out_sat, "R7 code in reset", enc_out_code, 0);
    check(dec_out_value == 0, "R7 value in reset", dec_out_value, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!enc_out_valid && !dec_out_valid, "R7 valids after reset", {enc_out_valid, dec_out_valid}, 0);

    // R2: listed expansion vectors
    run_dec(8'h00, val); check(val == 0, "R2 0x00", val, 0);
    run_dec(8'h0F, val); check(val == 15, "R2 0x0F", val, 15);
    run_dec(8'h1F, val); check(val == 46, "R2 0x1F", val, 46);
    run_dec(8'hF0, val); check(val == 524272, "R2 0xF0", val, 524272);
    run_dec(8'hFF, val); check(val == MAXV, "R2 0xFF", val, MAXV);

    // R1: fields of a known code (46 -> exponent 1, mantissa 15)
    run_enc(46, code, sat);
    check(code[7:4] == 1, "R1 exponent field", code[7:4], 1);
    check(code[3:0] == 15, "R1 mantissa field", code[3:0], 15);

    // R6: valid timing and hold with stimulus changing while idle
    @(negedge clk);
    enc_in_valid = 1'b1; enc_in_value = 20'd1000;
    dec_in_valid = 1'b1; dec_in_code = 8'h35;
    check(!enc_out_valid && !dec_out_valid, "R6 no valid before edge", {enc_out_valid, dec_out_valid}, 0);
    @(negedge clk);
    check(enc_out_valid && dec_out_valid, "R6 valid after one cycle", {enc_out_valid, dec_out_valid}, 3);
    check(enc_out_code == ref_enc(1000), "R6 both paths enc", enc_out_code, ref_enc(1000));
    check(dec_out_value == ref_dec(8'h35), "R6 both paths dec", dec_out_value, ref_dec(8'h35));
    enc_in_valid = 1'b0; enc_in_value = 20'd5;
    dec_in_valid = 1'b0; dec_in_code = 8'h00;
    @(negedge clk);
    check(!enc_out_valid && !dec_out_valid, "R6 valid drops", {enc_out_valid, dec_out_valid}, 0);
    check(enc_out_code == ref_enc(1000), "R6 code held", enc_out_code, ref_enc(1000));
    check(dec_out_value == ref_dec(8'h35), "R6 value held", dec_out_value, ref_dec(8'h35));

    // R3: every small input
    for (int v = 0; v < 16; v++) enc_check(v);

    // R4/R9: band edges for every exponent
    for (int e = 1; e < 16; e++) begin
      int unsigned lo = (2 ** e - 1) * 16;
      enc_check(lo - 1);
      enc_check(lo);
      enc_check(lo + 1);
      enc_check(lo + (2 ** e) - 1);
      enc_check(lo + (2 ** e));
    end

    // R4/R9: strided sweep over the whole range
    for (int unsigned v = 16; v <= MAXV; v += 211) enc_check(v);

    // R5: saturation boundary
    enc_check(MAXV);
    enc_check(MAXV + 1);
    enc_check(20'hFFFFF);

    // R2/R8: all codes expand correctly and round-trip through the DUT
    for (int c = 0; c < 256; c++) begin
      run_dec(c, val);
      check(val == ref_dec(c), "R2 expand sweep", val, ref_dec(c));
      run_enc(val, code, sat);
      check(code == c && !sat, "R8 round trip", code, c);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule